// File: doc/BRIEF.md
# Power-Up Strap and Status Sequencer

This block walks a platform through power-up, from the moment the suspend rail becomes good to the point where the processor runs with its frequency straps released. It holds the active-low sleep outputs, the suspend status and the bus reset asserted while the suspend rail comes up. After the resume reset is released and a programmable number of RTC ticks has elapsed, it starts the suspend clock and lifts the sleep outputs. Stop-clock and CPU-sleep are held inactive once the core rail is good.

The frequency strap lines go through three phases under control of a two-bit mode output. They are first driven high. They are switched to their strap values a fixed number of RTC ticks after both power-OK and regulator-good are seen. They are released a fixed number of 66 MHz ticks after the processor reports its reset complete. The block runs on a fast system clock and counts single-cycle tick strobes, so the long delays take little logic. Every delay is a parameter. If power-OK or regulator-good drops, the sequencer falls back to straps driven high with suspend status active. If the resume reset or the suspend rail is lost, it falls back further.

Top module: `pwr_strap_seq`

## Requirements
- R1: While reset is held and after it is released with all inputs low, slp_s3_n, slp_s5_n, sus_stat_n, bus_rst_n, stpclk_n and cpusleep_n are 0, susclk_en is 0, and strap_mode is 2'b01 (drive high).
- R2: While sus_good is low, one clock after it falls from any state, slp_s3_n, slp_s5_n, sus_stat_n, bus_rst_n, stpclk_n, cpusleep_n and susclk_en are all 0. With sus_good high and rsm_rel low, RTC ticks change none of them.
- R3: After rsm_rel rises, susclk_en, slp_s3_n and slp_s5_n stay 0 until the WAKE_TICKS-th rtc_tick strobe. On that strobe all three become 1 together.
- R4: stpclk_n and cpusleep_n equal 1 one clock after sus_good and core_good are both high, and 0 one clock after core_good is low.
- R5: With pwr_ok and vrm_good both held high after the suspend clock runs, sus_stat_n and bus_rst_n stay 0 and strap_mode stays 2'b01 until the LATCH_TICKS-th rtc_tick. On that strobe sus_stat_n and bus_rst_n become 1 and strap_mode becomes 2'b10 (strap value). fast_tick strobes do not advance this count, and pwr_ok alone does not start it.
- R6: With the straps at 2'b10, once cpu_rst_done is high, strap_mode turns 2'b00 (released) on the RELEASE_TICKS-th fast_tick strobe and not before. rtc_tick strobes do not advance this count.
- R7: One clock after pwr_ok or vrm_good is low, strap_mode is 2'b01 and sus_stat_n and bus_rst_n are 0. The strap-latch count restarts from zero when both are high again.
- R8: One clock after rsm_rel falls, slp_s3_n, slp_s5_n and susclk_en are 0.
- R9: strap_mode never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rtc_tick | input | 1 | One-cycle strobe per RTC period (about 32 us) |
| fast_tick | input | 1 | One-cycle strobe per 66 MHz period |
| sus_good | input | 1 | Suspend rail good |
| rsm_rel | input | 1 | Resume reset released |
| core_good | input | 1 | Core rail good |
| pwr_ok | input | 1 | Power-OK |
| vrm_good | input | 1 | Voltage regulator good |
| cpu_rst_done | input | 1 | Processor reset complete |
| slp_s3_n | output | 1 | Sleep (S3) output, active low |
| slp_s5_n | output | 1 | Sleep (S5) output, active low |
| sus_stat_n | output | 1 | Suspend status, active low |
| bus_rst_n | output | 1 | Bus reset, active low |
| stpclk_n | output | 1 | Stop-clock, active low |
| cpusleep_n | output | 1 | CPU sleep, active low |
| susclk_en | output | 1 | Suspend clock enable |
| strap_mode | output | 2 | Strap drive: 01 high, 10 strap value, 00 released |

## Verification
The bench aims at the edges of each counted delay. It checks one tick short of WAKE_TICKS, LATCH_TICKS and RELEASE_TICKS, then exactly at each. An off-by-one counter would latch or release a tick early or late. It sends strobes of the wrong kind into each counting phase, so a design that counts the wrong tick, or starts latching on power-OK alone, would move the straps too soon. It drops regulator-good partway through the latch count and then checks the full count again, which catches a counter that is not cleared. It also drops power-OK after release, then the resume reset, then the suspend rail, to show that each falls back to the right stage.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_SUS_WAIT, ST_WAKE_CNT, ST_SUS_ON,
    ST_LATCH_CNT, ST_LATCHED, ST_REL_CNT, ST_RUN
  } seq_state_e;

  typedef enum logic [1:0] {
    STRAP_FLOAT = 2'b00,
    STRAP_HIGH  = 2'b01,
    STRAP_VALUE = 2'b10
  } strap_mode_e;
endpackage

// File: rtl/pwrseq_tick_counter.sv
module pwrseq_tick_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  logic [CW-1:0] count_d;

  always_comb begin
    count_d = count;
    if (clr)      count_d = '0;
    else if (inc) count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (clr || inc) count <= count_d;
  end
endmodule

// File: rtl/pwrseq_out_decode.sv
module pwrseq_out_decode
  import pwrseq_pkg::*;
(
  input  seq_state_e state,
  output logic       slp_n,
  output logic       stat_n,
  output logic       clk_en,
  output logic [1:0] strap
);
  always_comb begin
    slp_n  = 1'b0;
    stat_n = 1'b0;
    clk_en = 1'b0;
    strap  = STRAP_HIGH;
    unique case (state)
      ST_OFF, ST_SUS_WAIT, ST_WAKE_CNT: ;
      ST_SUS_ON, ST_LATCH_CNT: begin
        slp_n  = 1'b1;
        clk_en = 1'b1;
      end
      ST_LATCHED, ST_REL_CNT: begin
        slp_n  = 1'b1;
        clk_en = 1'b1;
        stat_n = 1'b1;
        strap  = STRAP_VALUE;
      end
      ST_RUN: begin
        slp_n  = 1'b1;
        clk_en = 1'b1;
        stat_n = 1'b1;
        strap  = STRAP_FLOAT;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_strap_seq.sv
module pwr_strap_seq
  import pwrseq_pkg::*;
#(
  parameter int WAKE_TICKS    = 3438,
  parameter int LATCH_TICKS   = 33,
  parameter int RELEASE_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rtc_tick,
  input  logic       fast_tick,
  input  logic       sus_good,
  input  logic       rsm_rel,
  input  logic       core_good,
  input  logic       pwr_ok,
  input  logic       vrm_good,
  input  logic       cpu_rst_done,
  output logic       slp_s3_n,
  output logic       slp_s5_n,
  output logic       sus_stat_n,
  output logic       bus_rst_n,
  output logic       stpclk_n,
  output logic       cpusleep_n,
  output logic       susclk_en,
  output logic [1:0] strap_mode
);
  localparam int MAX_A = (WAKE_TICKS > LATCH_TICKS) ? WAKE_TICKS : LATCH_TICKS;
  localparam int MAX_T = (MAX_A > RELEASE_TICKS) ? MAX_A : RELEASE_TICKS;
  localparam int CW    = (MAX_T > 1) ? $clog2(MAX_T) : 1;
  localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_TICKS - 1);
  localparam logic [CW-1:0] LATCH_LAST = CW'(LATCH_TICKS - 1);
  localparam logic [CW-1:0] REL_LAST   = CW'(RELEASE_TICKS - 1);

  logic [1:0]    rst_sync;
  logic          rst_i_n;
  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt;
  logic          cnt_inc, cnt_clr;
  logic          pg;
  logic          core_q;
  logic          slp_n, stat_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign pg = pwr_ok & vrm_good;

  always_comb begin
    state_d = state_q;
    if (!sus_good) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:      state_d = ST_SUS_WAIT;
        ST_SUS_WAIT: if (rsm_rel) state_d = ST_WAKE_CNT;
        default: begin
          if (!rsm_rel) begin
            state_d = ST_SUS_WAIT;
          end else begin
            unique case (state_q)
              ST_WAKE_CNT:  if (rtc_tick && cnt == WAKE_LAST) state_d = ST_SUS_ON;
              ST_SUS_ON:    if (pg) state_d = ST_LATCH_CNT;
              ST_LATCH_CNT: if (!pg) state_d = ST_SUS_ON;
                            else if (rtc_tick && cnt == LATCH_LAST) state_d = ST_LATCHED;
              ST_LATCHED:   if (!pg) state_d = ST_SUS_ON;
                            else if (cpu_rst_done) state_d = ST_REL_CNT;
              ST_REL_CNT:   if (!pg) state_d = ST_SUS_ON;
                            else if (fast_tick && cnt == REL_LAST) state_d = ST_RUN;
              ST_RUN:       if (!pg) state_d = ST_SUS_ON;
              default:      state_d = ST_OFF;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= ST_OFF;
    else          state_q <= state_d;
  end

  assign cnt_clr = (state_d != state_q);
  assign cnt_inc = ((state_q == ST_WAKE_CNT || state_q == ST_LATCH_CNT) && rtc_tick)
                 || (state_q == ST_REL_CNT && fast_tick);

  pwrseq_tick_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .count (cnt)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) core_q <= 1'b0;
    else          core_q <= sus_good & core_good;
  end

  pwrseq_out_decode u_dec (
    .state  (state_q),
    .slp_n  (slp_n),
    .stat_n (stat_n),
    .clk_en (susclk_en),
    .strap  (strap_mode)
  );

  assign slp_s3_n   = slp_n;
  assign slp_s5_n   = slp_n;
  assign sus_stat_n = stat_n;
  assign bus_rst_n  = stat_n;
  assign stpclk_n   = core_q;
  assign cpusleep_n = core_q;
endmodule

// File: rtl/pwr_strap_seq_chk.sv
module pwr_strap_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rtc_tick,
  input logic       fast_tick,
  input logic       sus_good,
  input logic       core_good,
  input logic       pwr_ok,
  input logic       vrm_good,
  input logic       rsm_rel,
  input logic       slp_s3_n,
  input logic       slp_s5_n,
  input logic       sus_stat_n,
  input logic       bus_rst_n,
  input logic       stpclk_n,
  input logic       susclk_en,
  input logic [1:0] strap_mode
);
  a_r2_sus_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sus_good |=> (!slp_s3_n && !slp_s5_n && !sus_stat_n && !bus_rst_n && !susclk_en && !stpclk_n));

  a_r3_wake_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susclk_en) |-> (slp_s3_n && slp_s5_n && $past(rtc_tick)));

  a_r4_core_off: assert property (@(posedge clk) disable iff (!rst_n)
    !core_good |=> !stpclk_n);

  a_r4_core_on: assert property (@(posedge clk) disable iff (!rst_n)
    (sus_good && core_good) |=> stpclk_n);

  a_r5_latch_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sus_stat_n) |-> (strap_mode == 2'b10 && $past(rtc_tick) && $past(pwr_ok && vrm_good)));

  a_r6_release_on_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_mode == 2'b00 && $past(strap_mode) == 2'b10) |-> $past(fast_tick));

  a_r7_power_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_ok && vrm_good) |=> (strap_mode == 2'b01 && !sus_stat_n && !bus_rst_n));

  a_r8_resume_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !rsm_rel |=> (!susclk_en && !slp_s3_n));

  a_r9_strap_legal: assert property (@(posedge clk) disable iff (!rst_n)
    strap_mode != 2'b11);
endmodule

bind pwr_strap_seq pwr_strap_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rtc_tick   (rtc_tick),
  .fast_tick  (fast_tick),
  .sus_good   (sus_good),
  .core_good  (core_good),
  .pwr_ok     (pwr_ok),
  .vrm_good   (vrm_good),
  .rsm_rel    (rsm_rel),
  .slp_s3_n   (slp_s3_n),
  .slp_s5_n   (slp_s5_n),
  .sus_stat_n (sus_stat_n),
  .bus_rst_n  (bus_rst_n),
  .stpclk_n   (stpclk_n),
  .susclk_en  (susclk_en),
  .strap_mode (strap_mode)
);

// File: tb/pwr_strap_seq_tb.sv
module pwr_strap_seq_tb;
  localparam int WAKE  = 5;
  localparam int LATCH = 33;
  localparam int REL   = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic rtc_tick, fast_tick, sus_good, rsm_rel, core_good, pwr_ok, vrm_good, cpu_rst_done;
  logic slp_s3_n, slp_s5_n, sus_stat_n, bus_rst_n, stpclk_n, cpusleep_n, susclk_en;
  logic [1:0] strap_mode;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pwr_strap_seq #(.WAKE_TICKS(WAKE), .LATCH_TICKS(LATCH), .RELEASE_TICKS(REL)) u_dut (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .fast_tick(fast_tick),
    .sus_good(sus_good), .rsm_rel(rsm_rel), .core_good(core_good), .pwr_ok(pwr_ok),
    .vrm_good(vrm_good), .cpu_rst_done(cpu_rst_done), .slp_s3_n(slp_s3_n),
    .slp_s5_n(slp_s5_n), .sus_stat_n(sus_stat_n), .bus_rst_n(bus_rst_n),
    .stpclk_n(stpclk_n), .cpusleep_n(cpusleep_n), .susclk_en(susclk_en),
    .strap_mode(strap_mode)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // packs {slp_s3_n, slp_s5_n, sus_stat_n, bus_rst_n, stpclk_n, cpusleep_n, susclk_en}
  function automatic logic [7:0] outs();
    return {1'b0, slp_s3_n, slp_s5_n, sus_stat_n, bus_rst_n, stpclk_n, cpusleep_n, susclk_en};
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rtc_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      rtc_tick = 1'b1; @(negedge clk);
      rtc_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic fast_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      fast_tick = 1'b1; @(negedge clk);
      fast_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rtc_tick = 0; fast_tick = 0; sus_good = 0; rsm_rel = 0;
    core_good = 0; pwr_ok = 0; vrm_good = 0; cpu_rst_done = 0;
    idle(3);
    chk("R1 outputs in reset", outs(), 8'h00);
    chk("R1 strap in reset", {6'd0, strap_mode}, 8'h01);
    rst_n = 1'b1;
    idle(4);
    chk("R1 outputs after reset", outs(), 8'h00);
  endtask

  task automatic t_sus_only();
    sus_good = 1'b1;
    idle(3);
    rtc_pulses(10);
    chk("R2 no resume release, outputs held", outs(), 8'h00);
  endtask

  task automatic t_wake();
    rsm_rel = 1'b1;
    idle(2);
    rtc_pulses(WAKE - 1);
    chk("R3 one tick short of wake", outs(), 8'h00);
    rtc_pulses(1);
    chk("R3 wake tick", {7'd0, susclk_en}, 8'h01);
    chk("R3 sleep outputs lifted", {6'd0, slp_s3_n, slp_s5_n}, 8'h03);
  endtask

  task automatic t_core();
    core_good = 1'b1;
    idle(2);
    chk("R4 stop-clock and cpu-sleep inactive", {6'd0, stpclk_n, cpusleep_n}, 8'h03);
    chk("R4 strap still high", {6'd0, strap_mode}, 8'h01);
  endtask

  task automatic t_latch();
    pwr_ok = 1'b1;
    idle(2);
    rtc_pulses(40);
    chk("R5 power-OK alone does not latch", {6'd0, sus_stat_n, bus_rst_n}, 8'h00);
    vrm_good = 1'b1;
    idle(2);
    fast_pulses(50);
    chk("R5 fast ticks do not count", {6'd0, strap_mode}, 8'h01);
    rtc_pulses(LATCH - 1);
    chk("R5 one tick short of latch", {6'd0, sus_stat_n, strap_mode[1]}, 8'h00);
    rtc_pulses(1);
    chk("R5 latch status", {6'd0, sus_stat_n, bus_rst_n}, 8'h03);
    chk("R5 strap value", {6'd0, strap_mode}, 8'h02);
  endtask

  task automatic t_release();
    cpu_rst_done = 1'b1;
    idle(2);
    rtc_pulses(20);
    chk("R6 rtc ticks do not release", {6'd0, strap_mode}, 8'h02);
    fast_pulses(REL - 1);
    chk("R6 one tick short of release", {6'd0, strap_mode}, 8'h02);
    fast_pulses(1);
    chk("R6 released", {6'd0, strap_mode}, 8'h00);
  endtask

  task automatic t_pwr_drop();
    pwr_ok = 1'b0;
    idle(2);
    chk("R7 strap back to high", {6'd0, strap_mode}, 8'h01);
    chk("R7 status reasserted", {6'd0, sus_stat_n, bus_rst_n}, 8'h00);
    pwr_ok = 1'b1;
    idle(2);
    rtc_pulses(10);
    vrm_good = 1'b0;
    idle(2);
    vrm_good = 1'b1;
    idle(2);
    rtc_pulses(LATCH - 1);
    chk("R7 count restarted after regulator drop", {6'd0, sus_stat_n, strap_mode[1]}, 8'h00);
    rtc_pulses(1);
    chk("R7 latch after full recount", {6'd0, strap_mode}, 8'h02);
  endtask

  task automatic t_rsm_drop();
    rsm_rel = 1'b0;
    idle(2);
    chk("R8 resume drop", {5'd0, slp_s3_n, slp_s5_n, susclk_en}, 8'h00);
    chk("R8 straps back high", {6'd0, strap_mode}, 8'h01);
  endtask

  task automatic t_sus_drop();
    rsm_rel = 1'b1;
    idle(3);
    sus_good = 1'b0;
    idle(2);
    chk("R2 suspend rail drop", outs(), 8'h00);
    chk("R9 strap legal at end", {7'd0, strap_mode == 2'b11}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_sus_only();
    t_wake();
    t_core();
    t_latch();
    t_release();
    t_pwr_drop();
    t_rsm_drop();
    t_sus_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule